// File: doc/BRIEF.md
# Edge Timestamp Capture Logger

This block timestamps the edges of an asynchronous input signal. A free-running 32-bit counter advances once per clock. Each time the selected edge of the input arrives, the counter value is written into an on-chip circular buffer, with no processor involvement. The buffer is split into two halves, and each half raises its own sticky event when its last entry is written. A host can therefore drain one half while the other half fills. After the final entry, writing wraps to the first entry and carries on without stopping.

The input passes through a two-flop synchroniser before edge detection. The time between two edges is the unsigned 32-bit difference of consecutive entries, and that difference stays correct across a counter wrap. The host reads any entry by index through a registered port with one cycle of latency. Each event flag is cleared by a one-cycle pulse on its own clear input. An overrun flag records that a half was completed again before its event had been cleared.

Top module: `edge_stamp_logger`

## Requirements
- R1: After reset, all three flags are 0, the counter reads 0 in the first cycle after reset is released, and the first capture is stored at index 0.
- R2: With `fall_sel`=0, only 0-to-1 transitions of `sig_in` are captured. The stored value is the counter value two clocks after the clock edge at which the new input level is first sampled. That is, an input change followed by three rising clock edges stores the counter value of the third.
- R3: With `fall_sel`=1, only 1-to-0 transitions are captured, with the same timing as R2, and 0-to-1 transitions store nothing.
- R4: Captures fill consecutive indices starting at 0, and the index after DEPTH-1 (127 by default) is 0.
- R5: `half_evt` rises in the cycle after the entry at index DEPTH/2-1 is written. `full_evt` rises in the cycle after the entry at index DEPTH-1 is written.
- R6: Each event stays at 1 until a one-cycle pulse on its own clear input (`half_clr` or `full_clr`). The flag then reads 0 in the next cycle.
- R7: If a clear arrives in the same cycle as a new completion of that half, the completion wins. The flag stays at 1 and no overrun is recorded.
- R8: A completion of a half whose event is still 1, with no clear in that cycle, sets `ovr_evt`. `ovr_evt` then stays at 1 until reset.
- R9: `rd_data` shows the entry at `rd_idx` one clock after `rd_idx` is applied, and keeps the previously selected entry until that clock.
- R10: The counter advances by exactly one per clock, modulo 2^32. The difference between two stored entries therefore equals the number of clocks between the two input edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous signal whose edges are timestamped |
| fall_sel | input | 1 | 0 captures rising edges, 1 captures falling edges |
| half_clr | input | 1 | Clear pulse for the first-half event |
| full_clr | input | 1 | Clear pulse for the second-half event |
| rd_idx | input | 7 | Buffer index for the host read |
| rd_data | output | 32 | Entry at the index applied one cycle earlier |
| half_evt | output | 1 | Sticky event: first half written |
| full_evt | output | 1 | Sticky event: second half written |
| ovr_evt | output | 1 | Sticky event: a half was completed again before its event was cleared |

## Verification
A host clear pulse and the completion of the same half can fall in the same clock, since the host drains on its own schedule. The bench lets the buffer fill once so that the first-half event is set. It then times `half_clr` to land exactly on the clock that writes index 63 on the second pass. It judges that the flag is still 1 and that `ovr_evt` stayed 0. A separate run omits the clear so that the same completion must raise `ovr_evt`.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
    localparam int STAMP_W_DEF = 32;
    localparam int DEPTH_DEF   = 128;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic                   hit;
        logic [STAMP_W_DEF-1:0] stamp;
    } capture_t;

    function automatic logic edge_seen(edge_pol_e pol, logic cur, logic prev);
        return (pol == POL_RISE) ? (cur & ~prev) : (~cur & prev);
    endfunction
endpackage

// File: rtl/esl_input_front.sv
module esl_input_front
    import edge_stamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_in,
    input  edge_pol_e pol,
    output logic      hit
);
    // Stages 0..SYNC_STAGES-1 synchronise; the extra stage holds the previous level.
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], sig_in};
    end

    assign hit = edge_seen(pol, chain_q[SYNC_STAGES-1], chain_q[SYNC_STAGES]);
endmodule

// File: rtl/esl_free_counter.sv
module esl_free_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/esl_ring_ctrl.sv
module esl_ring_ctrl #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    seg_clr,
    output logic [AW-1:0] wr_ptr,
    output logic [1:0]    seg_evt,
    output logic          ovr_evt
);
    logic [1:0] ovr_hit;

    always_ff @(posedge clk) begin
        if (rst)        wr_ptr <= '0;
        else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_seg
        localparam logic [AW-1:0] LAST_IDX = AW'((g + 1) * HALF - 1);
        logic done;
        logic flag_q;

        assign done = wr_en && (wr_ptr == LAST_IDX);

        always_ff @(posedge clk) begin
            if (rst)             flag_q <= 1'b0;
            else if (done)       flag_q <= 1'b1;
            else if (seg_clr[g]) flag_q <= 1'b0;
        end

        assign ovr_hit[g] = done && flag_q && !seg_clr[g];
        assign seg_evt[g] = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst)           ovr_evt <= 1'b0;
        else if (|ovr_hit) ovr_evt <= 1'b1;
    end
endmodule

// File: rtl/esl_ring_store.sv
module esl_ring_store #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  rd
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        rd <= mem[ra];
    end
endmodule

// File: rtl/edge_stamp_logger.sv
module edge_stamp_logger
    import edge_stamp_pkg::*;
#(
    parameter int DEPTH       = DEPTH_DEF,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sig_in,
    input  logic                   fall_sel,
    input  logic                   half_clr,
    input  logic                   full_clr,
    input  logic [AW-1:0]          rd_idx,
    output logic [STAMP_W_DEF-1:0] rd_data,
    output logic                   half_evt,
    output logic                   full_evt,
    output logic                   ovr_evt
);
    capture_t                 cap;
    logic [STAMP_W_DEF-1:0]   stamp_cnt;
    logic [AW-1:0]            wr_ptr;
    logic [1:0]               seg_evt;
    edge_pol_e                pol;

    assign pol = edge_pol_e'(fall_sel);

    esl_input_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .sig_in(sig_in), .pol(pol), .hit(cap.hit)
    );

    esl_free_counter #(.W(STAMP_W_DEF)) u_cnt (
        .clk(clk), .rst(rst), .cnt(stamp_cnt)
    );

    assign cap.stamp = stamp_cnt;

    esl_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(cap.hit), .seg_clr({full_clr, half_clr}),
        .wr_ptr(wr_ptr), .seg_evt(seg_evt), .ovr_evt(ovr_evt)
    );

    esl_ring_store #(.DEPTH(DEPTH), .W(STAMP_W_DEF)) u_store (
        .clk(clk), .we(cap.hit), .wa(wr_ptr), .wd(cap.stamp),
        .ra(rd_idx), .rd(rd_data)
    );

    assign half_evt = seg_evt[0];
    assign full_evt = seg_evt[1];
endmodule

// File: rtl/esl_checker.sv
module esl_checker #(
    parameter int DEPTH   = 128,
    parameter int STAMP_W = 32,
    localparam int AW     = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [AW-1:0]      wr_ptr,
    input logic [STAMP_W-1:0] cnt,
    input logic               half_clr,
    input logic               half_evt,
    input logic               full_evt,
    input logic               ovr_evt
);
    localparam logic [AW-1:0] MID_IDX  = AW'(DEPTH / 2 - 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
        armed |-> cnt == $past(cnt) + 1'b1);

    // R4: pointer advances by one per capture, wrapping at DEPTH
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(wr_en)) |-> wr_ptr == $past(wr_ptr) + 1'b1);

    p_half_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ptr == MID_IDX) |=> half_evt);

    p_full_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ptr == LAST_IDX) |=> full_evt);

    p_half_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (half_evt && !half_clr) |=> half_evt);

    p_half_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (half_clr && !(wr_en && wr_ptr == MID_IDX)) |=> !half_evt);

    p_clear_wins_none_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ptr == MID_IDX && half_clr && !ovr_evt) |=> !ovr_evt);

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ptr == MID_IDX && half_evt && !half_clr) |=> ovr_evt);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> ovr_evt);
endmodule

bind edge_stamp_logger esl_checker #(.DEPTH(DEPTH), .STAMP_W(edge_stamp_pkg::STAMP_W_DEF)) u_chk (
    .clk(clk), .rst(rst), .wr_en(cap.hit), .wr_ptr(wr_ptr), .cnt(stamp_cnt),
    .half_clr(half_clr), .half_evt(half_evt), .full_evt(full_evt), .ovr_evt(ovr_evt)
);

// File: tb/edge_stamp_logger_tb.sv
`timescale 1ns/1ps
module edge_stamp_logger_tb;
    localparam int DEPTH = 128;
    localparam int AW    = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sig_in = 1'b0;
    logic          fall_sel = 1'b0;
    logic          half_clr = 1'b0;
    logic          full_clr = 1'b0;
    logic [AW-1:0] rd_idx = '0;
    logic [31:0]   rd_data;
    logic          half_evt, full_evt, ovr_evt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] tb_cyc;
    logic [31:0] exp_tab [DEPTH];
    int          wr_model;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) tb_cyc <= rst ? 32'd0 : tb_cyc + 32'd1;

    edge_stamp_logger u_dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .fall_sel(fall_sel),
        .half_clr(half_clr), .full_clr(full_clr), .rd_idx(rd_idx),
        .rd_data(rd_data), .half_evt(half_evt), .full_evt(full_evt), .ovr_evt(ovr_evt)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sig_in = 1'b0; half_clr = 1'b0; full_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wr_model = 0;
    endtask

    // Drive a new input level at a falling clock edge and book the expected capture.
    task automatic drive(input logic lvl, input int hold);
        @(negedge clk);
        sig_in = lvl;
        if ((fall_sel == 1'b0 && lvl == 1'b1) || (fall_sel == 1'b1 && lvl == 1'b0)) begin
            exp_tab[wr_model % DEPTH] = tb_cyc + 32'd2;
            wr_model++;
        end
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        drive(1'b1, hi);
        drive(1'b0, lo);
    endtask

    task automatic read_entry(input int idx, output logic [31:0] val);
        @(negedge clk);
        rd_idx = AW'(idx);
        @(negedge clk);
        val = rd_data;
    endtask

    task automatic pulse_clear(input bit half);
        @(negedge clk);
        if (half) half_clr = 1'b1; else full_clr = 1'b1;
        @(negedge clk);
        half_clr = 1'b0; full_clr = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        do_reset();
        chk(half_evt == 0 && full_evt == 0 && ovr_evt == 0, "R1 flags after reset",
            {29'd0, half_evt, full_evt, ovr_evt}, 32'd0);
        pulse(4, 4);
        read_entry(0, v);
        chk(v == exp_tab[0], "R1 first capture at index 0", v, exp_tab[0]);
    endtask

    task automatic test_rise();
        logic [31:0] v, prev;
        do_reset();
        fall_sel = 1'b0;
        for (int i = 0; i < 6; i++) pulse(3 + i, 4 + 2 * i);
        for (int i = 0; i < 6; i++) begin
            read_entry(i, v);
            chk(v == exp_tab[i], "R2 rising stamp", v, exp_tab[i]);
            if (i > 0) chk(v - prev == exp_tab[i] - exp_tab[i-1], "R10 interval", v - prev,
                           exp_tab[i] - exp_tab[i-1]);
            prev = v;
        end
    endtask

    task automatic test_fall();
        logic [31:0] v;
        do_reset();
        fall_sel = 1'b1;
        for (int i = 0; i < 4; i++) pulse(5 + i, 3);
        for (int i = 0; i < 4; i++) begin
            read_entry(i, v);
            chk(v == exp_tab[i], "R3 falling stamp", v, exp_tab[i]);
        end
        fall_sel = 1'b0;
    endtask

    task automatic test_half_full();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < DEPTH / 2 - 1; i++) pulse(3, 3);
        chk(half_evt == 0, "R5 half not yet", half_evt, 0);
        pulse(3, 3);
        chk(half_evt == 1 && full_evt == 0, "R5 half event", {half_evt, full_evt}, 2'b10);
        for (int i = DEPTH / 2; i < DEPTH; i++) pulse(3, 3);
        chk(full_evt == 1, "R5 full event", full_evt, 1);
        chk(half_evt == 1, "R6 half sticky", half_evt, 1);
        read_entry(DEPTH - 1, v);
        chk(v == exp_tab[DEPTH - 1], "R4 last entry", v, exp_tab[DEPTH - 1]);
        pulse(3, 3);
        read_entry(0, v);
        chk(v == exp_tab[0], "R4 wrap to index 0", v, exp_tab[0]);
        read_entry(1, v);
        chk(v != exp_tab[0], "R4 wrap not at index 1", v, exp_tab[0]);
        pulse_clear(1'b1);
        chk(half_evt == 0 && full_evt == 1, "R6 half clear only", {half_evt, full_evt}, 2'b01);
        pulse_clear(1'b0);
        chk(full_evt == 0 && ovr_evt == 0, "R6 full clear", {full_evt, ovr_evt}, 2'b00);
    endtask

    task automatic test_coincide();
        do_reset();
        for (int i = 0; i < DEPTH; i++) pulse(3, 3);
        pulse_clear(1'b0);
        for (int i = 0; i < DEPTH / 2 - 1; i++) pulse(3, 3);
        @(negedge clk);
        sig_in = 1'b1;
        exp_tab[wr_model % DEPTH] = tb_cyc + 32'd2;
        wr_model++;
        @(negedge clk);
        @(negedge clk);
        half_clr = 1'b1;
        @(negedge clk);
        half_clr = 1'b0;
        chk(half_evt == 1, "R7 completion beats clear", half_evt, 1);
        chk(ovr_evt == 0, "R7 no overrun on coincident clear", ovr_evt, 0);
        drive(1'b0, 3);
    endtask

    task automatic test_overrun();
        do_reset();
        for (int i = 0; i < DEPTH + DEPTH / 2 - 1; i++) pulse(3, 3);
        chk(ovr_evt == 0, "R8 no overrun yet", ovr_evt, 0);
        pulse(3, 3);
        chk(ovr_evt == 1, "R8 overrun set", ovr_evt, 1);
        pulse_clear(1'b1);
        pulse_clear(1'b0);
        chk(ovr_evt == 1, "R8 overrun sticky", ovr_evt, 1);
    endtask

    task automatic test_read_latency();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 3; i++) pulse(4, 5);
        read_entry(2, v);
        @(negedge clk);
        rd_idx = AW'(1);
        #1;
        chk(rd_data == exp_tab[2], "R9 holds old entry before edge", rd_data, exp_tab[2]);
        @(negedge clk);
        chk(rd_data == exp_tab[1], "R9 new entry after one edge", rd_data, exp_tab[1]);
    endtask

    initial begin
        test_reset();
        test_rise();
        test_fall();
        test_half_full();
        test_coincide();
        test_overrun();
        test_read_latency();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule